// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets clocked logic read and write an external 2048 x 8 asynchronous static RAM. The host side uses a valid/ready request port. Each request carries a direction flag, an 11-bit word address and a byte of write data. Read results come back on a separate data output, marked by a one-cycle valid pulse. On the memory side the controller drives three active-low strobes (select, output enable, write enable), the address lines and a shared bidirectional data bus.

The memory has no clock, so every timing limit it imposes is given in picoseconds as a parameter. These limits are:

- address setup before the write starts and before the write ends
- write-enable pulse width
- data setup and data hold around the end of the write
- write and read cycle times
- address access time and output-enable access time
- output-enable release time

Each limit is rounded up to a whole number of cycles of the clock-period parameter. The strobes are then stepped by counters so that every limit is met.

A write always ends on the rising edge of write enable, while select is still low. The controller drives the data bus only while output enable is high. After a read it waits for the memory to release the bus before it takes any new request. While idle, select stays high so the memory sits in its low-power state.

Top module: `sram_async_ctrl`

## Requirements
- R1: While the synchronous reset is high, and in the cycle after it, the three strobes are high, the controller's data drivers are off, request ready is high and read-data-valid is low.
- R2: Request ready is high only in the idle state. A request is taken on a clock edge where valid and ready are both high, and ready then stays low until the memory cycle is over.
- R3: During a write, write enable goes low only while select is low, and output enable stays high for the whole write. The byte on the bus is stored at the request address.
- R4: For each write, the memory sees three minimums, each rounded up to whole clock periods. Write enable stays low for at least the pulse minimum. The address is stable for at least the address-to-end minimum before write enable rises. The written byte is on the bus for at least the data-setup minimum before write enable rises.
- R5: The data drivers turn on one cycle after write enable falls and turn off one cycle after write enable rises. Select stays low during that last cycle, so write enable is always the edge that ends the write.
- R6: A read holds select and output enable low, with write enable high, for max(address access, output-enable access, read cycle, one) cycles, each rounded up. The bus is captured on the last of those cycles. Read-data-valid is then high for exactly one cycle with the captured byte.
- R7: After a read, output enable stays high for max(1, rounded-up release time) cycles before a new request can be taken. The data drivers are never on while output enable is low.
- R8: Whenever the controller is idle, select is high.
- R9: The number of cycles ready stays low is fixed for each kind of request. For a write it is S + P + H, where S is the setup count, P = max(pulse, address-to-end minus S, data setup + 1, 2) and H = max(1, data hold, write cycle minus S minus P). For a read it is the access count plus the release count. With the default parameters and a 5 ns clock this is 4 cycles for a write and 6 for a read.
- R10: All 2048 word addresses, 0 through 2047, can be written and read back, including both ends of the range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 11 | Word address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse: read data present |
| rsp_rdata | output | 8 | Captured read byte |
| sram_ce_n | output | 1 | Memory select, active low |
| sram_oe_n | output | 1 | Memory output enable, active low |
| sram_we_n | output | 1 | Memory write enable, active low |
| sram_addr | output | 11 | Memory address lines |
| sram_dq | inout | 8 | Shared memory data bus |

## Verification
When requests are issued back to back, two things happen in the same idle cycle: one memory cycle finishes (all strobes return high) and the next request is accepted. Likewise, the edge that captures read data is also the edge that raises output enable to start the bus release. The bench provokes both by having its driver present a new request in the very first idle cycle after each operation. It mixes writes and reads of the same address, including a write immediately followed by a read of that address.

Each case is judged three ways. The ready-low span is compared with the cycle counts in R9. Strobe and bus timing is measured in absolute time at the memory model. The returned byte is compared against a reference copy of memory kept by the bench.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WSETUP = 3'd1,
        ST_WPULSE = 3'd2,
        ST_WHOLD  = 3'd3,
        ST_RACC   = 3'd4,
        ST_RREL   = 3'd5
    } seq_state_e;

    // Round a time up to whole clock periods; zero stays zero.
    function automatic int unsigned ps_to_cycles(input int unsigned t_ps,
                                                 input int unsigned clk_ps);
        return (t_ps + clk_ps - 1) / clk_ps;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Subtraction clamped at zero.
    function automatic int unsigned usub(input int unsigned a, input int unsigned b);
        return (a > b) ? (a - b) : 0;
    endfunction

endpackage

// File: rtl/sram_ctrl_seq.sv
module sram_ctrl_seq
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned CNT_W     = 3,
    parameter int unsigned N_SETUP   = 0,
    parameter int unsigned N_PULSE   = 3,
    parameter int unsigned N_HOLD    = 1,
    parameter int unsigned N_ACCESS  = 4,
    parameter int unsigned N_RELEASE = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic req_valid,
    input  logic req_write,
    output logic req_ready,
    output logic accept,
    output logic capture,
    output logic ce_n,
    output logic oe_n,
    output logic we_n,
    output logic drv
);

    // Counter reload values: a phase of N cycles counts N-1 down to 0.
    localparam logic [CNT_W-1:0] L_SETUP   = CNT_W'(usub(N_SETUP, 1));
    localparam logic [CNT_W-1:0] L_PULSE   = CNT_W'(usub(N_PULSE, 1));
    localparam logic [CNT_W-1:0] L_HOLD    = CNT_W'(usub(N_HOLD, 1));
    localparam logic [CNT_W-1:0] L_ACCESS  = CNT_W'(usub(N_ACCESS, 1));
    localparam logic [CNT_W-1:0] L_RELEASE = CNT_W'(usub(N_RELEASE, 1));
    localparam bit               HAS_SETUP = (N_SETUP != 0);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             ce_n;
        logic             oe_n;
        logic             we_n;
        logic             drv;
    } seq_regs_t;

    seq_regs_t seq_d, seq_q;
    logic      accept_d, capture_d;
    logic      cnt_zero;

    assign cnt_zero = (seq_q.cnt == '0);

    always_comb begin
        seq_d     = seq_q;
        accept_d  = 1'b0;
        capture_d = 1'b0;
        case (seq_q.st)
            ST_IDLE: begin
                seq_d.ce_n = 1'b1;
                seq_d.oe_n = 1'b1;
                seq_d.we_n = 1'b1;
                seq_d.drv  = 1'b0;
                if (req_valid) begin
                    accept_d   = 1'b1;
                    seq_d.ce_n = 1'b0;
                    if (req_write) begin
                        if (HAS_SETUP) begin
                            seq_d.st  = ST_WSETUP;
                            seq_d.cnt = L_SETUP;
                        end else begin
                            seq_d.st   = ST_WPULSE;
                            seq_d.we_n = 1'b0;
                            seq_d.cnt  = L_PULSE;
                        end
                    end else begin
                        seq_d.st   = ST_RACC;
                        seq_d.oe_n = 1'b0;
                        seq_d.cnt  = L_ACCESS;
                    end
                end
            end
            ST_WSETUP: begin
                if (cnt_zero) begin
                    seq_d.st   = ST_WPULSE;
                    seq_d.we_n = 1'b0;
                    seq_d.cnt  = L_PULSE;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_WPULSE: begin
                // drivers follow write enable by one cycle
                seq_d.drv = 1'b1;
                if (cnt_zero) begin
                    seq_d.st   = ST_WHOLD;
                    seq_d.we_n = 1'b1;
                    seq_d.cnt  = L_HOLD;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_WHOLD: begin
                seq_d.drv = 1'b0;
                if (cnt_zero) begin
                    seq_d.st   = ST_IDLE;
                    seq_d.ce_n = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_RACC: begin
                if (cnt_zero) begin
                    capture_d  = 1'b1;
                    seq_d.st   = ST_RREL;
                    seq_d.ce_n = 1'b1;
                    seq_d.oe_n = 1'b1;
                    seq_d.cnt  = L_RELEASE;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            ST_RREL: begin
                if (cnt_zero) begin
                    seq_d.st = ST_IDLE;
                end else begin
                    seq_d.cnt = seq_q.cnt - 1'b1;
                end
            end
            default: begin
                seq_d = '{st: ST_IDLE, cnt: '0, ce_n: 1'b1, oe_n: 1'b1,
                          we_n: 1'b1, drv: 1'b0};
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q <= '{st: ST_IDLE, cnt: '0, ce_n: 1'b1, oe_n: 1'b1,
                       we_n: 1'b1, drv: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready = (seq_q.st == ST_IDLE);
    assign accept    = accept_d;
    assign capture   = capture_d;
    assign ce_n      = seq_q.ce_n;
    assign oe_n      = seq_q.oe_n;
    assign we_n      = seq_q.we_n;
    assign drv       = seq_q.drv;

endmodule

// File: rtl/sram_ctrl_dpath.sv
module sram_ctrl_dpath #(
    parameter int unsigned ADDR_W = 11,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] bus_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } dp_regs_t;

    dp_regs_t dp_d, dp_q;

    always_comb begin
        dp_d        = dp_q;
        dp_d.rvalid = capture;
        if (accept) begin
            dp_d.addr  = req_addr;
            dp_d.wdata = req_wdata;
        end
        if (capture) begin
            dp_d.rdata = bus_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign mem_addr  = dp_q.addr;
    assign mem_wdata = dp_q.wdata;
    assign rsp_valid = dp_q.rvalid;
    assign rsp_rdata = dp_q.rdata;

endmodule

// File: rtl/sram_ctrl_pad.sv
module sram_ctrl_pad #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              drv,
    input  logic [DATA_W-1:0] dout,
    output logic [DATA_W-1:0] din,
    inout  wire  [DATA_W-1:0] bus
);

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        assign bus[b] = drv ? dout[b] : 1'bz;
        assign din[b] = bus[b];
    end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W        = 11,
    parameter int unsigned DATA_W        = 8,
    parameter int unsigned CLK_PS        = 5000,
    parameter int unsigned T_ADDR_SETUP  = 0,
    parameter int unsigned T_ADDR_TO_END = 15000,
    parameter int unsigned T_WE_PULSE    = 15000,
    parameter int unsigned T_DATA_SETUP  = 10000,
    parameter int unsigned T_DATA_HOLD   = 0,
    parameter int unsigned T_WCYCLE      = 20000,
    parameter int unsigned T_RCYCLE      = 20000,
    parameter int unsigned T_ADDR_ACC    = 20000,
    parameter int unsigned T_OE_ACC      = 10000,
    parameter int unsigned T_OE_RELEASE  = 8000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic [ADDR_W-1:0] sram_addr,
    inout  wire  [DATA_W-1:0] sram_dq
);

    localparam int unsigned C_SETUP = ps_to_cycles(T_ADDR_SETUP, CLK_PS);
    localparam int unsigned C_AEND  = ps_to_cycles(T_ADDR_TO_END, CLK_PS);
    localparam int unsigned C_WP    = ps_to_cycles(T_WE_PULSE, CLK_PS);
    localparam int unsigned C_DS    = ps_to_cycles(T_DATA_SETUP, CLK_PS);
    localparam int unsigned C_DH    = ps_to_cycles(T_DATA_HOLD, CLK_PS);
    localparam int unsigned C_WC    = ps_to_cycles(T_WCYCLE, CLK_PS);
    localparam int unsigned C_RC    = ps_to_cycles(T_RCYCLE, CLK_PS);
    localparam int unsigned C_AA    = ps_to_cycles(T_ADDR_ACC, CLK_PS);
    localparam int unsigned C_OE    = ps_to_cycles(T_OE_ACC, CLK_PS);
    localparam int unsigned C_OHZ   = ps_to_cycles(T_OE_RELEASE, CLK_PS);

    // Pulse must cover width, address-to-end, and data setup after the
    // one-cycle driver delay.
    localparam int unsigned C_PULSE   = umax(umax(C_WP, usub(C_AEND, C_SETUP)),
                                             umax(C_DS + 1, 2));
    localparam int unsigned C_HOLD    = umax(umax(1, C_DH),
                                             usub(C_WC, C_SETUP + C_PULSE));
    localparam int unsigned C_ACCESS  = umax(umax(C_AA, C_OE), umax(C_RC, 1));
    localparam int unsigned C_RELEASE = umax(1, C_OHZ);
    localparam int unsigned C_MAX     = umax(umax(C_SETUP, C_PULSE),
                                             umax(umax(C_HOLD, C_ACCESS), C_RELEASE));
    localparam int unsigned CNT_W     = $clog2(C_MAX + 1);

    logic              accept;
    logic              capture;
    logic              dq_drive;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] bus_in;

    sram_ctrl_seq #(
        .CNT_W    (CNT_W),
        .N_SETUP  (C_SETUP),
        .N_PULSE  (C_PULSE),
        .N_HOLD   (C_HOLD),
        .N_ACCESS (C_ACCESS),
        .N_RELEASE(C_RELEASE)
    ) seq_i (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_ready(req_ready),
        .accept   (accept),
        .capture  (capture),
        .ce_n     (sram_ce_n),
        .oe_n     (sram_oe_n),
        .we_n     (sram_we_n),
        .drv      (dq_drive)
    );

    sram_ctrl_dpath #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W)
    ) dpath_i (
        .clk      (clk),
        .rst      (rst),
        .accept   (accept),
        .capture  (capture),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .bus_in   (bus_in),
        .mem_addr (sram_addr),
        .mem_wdata(wdata_q),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata)
    );

    sram_ctrl_pad #(
        .DATA_W(DATA_W)
    ) pad_i (
        .drv (dq_drive),
        .dout(wdata_q),
        .din (bus_in),
        .bus (sram_dq)
    );

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic rsp_valid,
    input logic ce_n,
    input logic oe_n,
    input logic we_n,
    input logic drv
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (ce_n && oe_n && we_n && !drv && req_ready && !rsp_valid));

    // R2
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R3
    write_selected_chk: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> (!ce_n && oe_n));

    // R5
    drive_after_we_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(we_n) |=> drv);

    // R5
    drive_through_we_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |-> (drv && !ce_n));

    // R5
    drive_off_after_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(we_n) |=> !drv);

    // R6
    rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    // R7
    no_contention_chk: assert property (@(posedge clk) disable iff (rst)
        drv |-> oe_n);

    // R8
    idle_deselect_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> ce_n);

endmodule

bind sram_async_ctrl sram_ctrl_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .rsp_valid(rsp_valid),
    .ce_n     (sram_ce_n),
    .oe_n     (sram_oe_n),
    .we_n     (sram_we_n),
    .drv      (dq_drive)
);

// File: tb/sram_async_ctrl_tb_top.sv
module sram_async_ctrl_tb_top;

    localparam int CLK_PS   = 5000;
    localparam int HALF_PS  = 2500;
    localparam int T_AEND   = 15000;
    localparam int T_WP     = 15000;
    localparam int T_DS     = 10000;
    localparam int T_AA     = 20000;
    localparam int T_OE     = 10000;

    // R9 expected busy lengths from the requirement formulas
    // (setup 0, pulse max(3,3,3,2)=3, hold max(1,0,4-3)=1; access 4, release 2)
    localparam int W_BUSY = 4;
    localparam int R_BUSY = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [10:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic [7:0]  rsp_rdata;
    logic        sram_ce_n, sram_oe_n, sram_we_n;
    logic [10:0] sram_addr;
    wire  [7:0]  sram_dq;

    int n_chk = 0;
    int n_bad = 0;

    always #HALF_PS clk = ~clk;

    sram_async_ctrl dut_i (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_ready(req_ready),
        .req_write(req_write),
        .req_addr (req_addr),
        .req_wdata(req_wdata),
        .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata),
        .sram_ce_n(sram_ce_n),
        .sram_oe_n(sram_oe_n),
        .sram_we_n(sram_we_n),
        .sram_addr(sram_addr),
        .sram_dq  (sram_dq)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // ---------------- memory model ----------------
    logic [7:0] mem [2048];
    logic [7:0] ref_mem [2048];
    logic       mdl_drive;
    longint     t_we_fall = 0, t_addr_chg = 0, t_dq_chg = 0, t_oe_fall = 0;

    assign mdl_drive = !sram_ce_n && !sram_oe_n && sram_we_n;
    assign sram_dq   = mdl_drive ? mem[sram_addr] : 8'bz;

    initial begin
        for (int i = 0; i < 2048; i++) begin
            mem[i]     = 8'h00;
            ref_mem[i] = 8'h00;
        end
    end

    always @(negedge sram_we_n) t_we_fall = $time;
    always @(negedge sram_oe_n) t_oe_fall = $time;
    always @(sram_addr)         t_addr_chg = $time;
    always @(sram_dq)           t_dq_chg = $time;

    always @(posedge sram_we_n) begin
        if (!rst && !sram_ce_n) begin
            mem[sram_addr] = sram_dq;
            // R4 pulse width, address and data setup to write end
            check(($time - t_we_fall) >= T_WP, "R4 we pulse", $time - t_we_fall, T_WP);
            check(($time - t_addr_chg) >= T_AEND, "R4 addr to end", $time - t_addr_chg, T_AEND);
            check(($time - t_dq_chg) >= T_DS, "R4 data setup", $time - t_dq_chg, T_DS);
            // R3 output enable held high during write
            check(sram_oe_n == 1'b1, "R3 oe high in write", sram_oe_n, 1);
        end
    end

    always @(posedge sram_ce_n) begin
        if (!rst && !sram_we_n) begin
            mem[sram_addr] = sram_dq;
            // R5 write must end on write enable, not select
            check(1'b0, "R5 write ended by select", 1, 0);
        end
    end

    // ---------------- scoreboard ----------------
    logic [7:0] exp_q  [$];
    int         busy_q [$];
    int         busy_cnt = 0;

    task automatic issue(input bit wr, input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        if (wr) begin
            ref_mem[a] = d;
            busy_q.push_back(W_BUSY);
        end else begin
            exp_q.push_back(ref_mem[a]);
            busy_q.push_back(R_BUSY);
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (rsp_valid) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected read data", rsp_rdata, 0);
                end else begin
                    automatic logic [7:0] e = exp_q.pop_front();
                    // R6 R10 returned byte
                    check(rsp_rdata == e, "R6 read data", rsp_rdata, e);
                    // R6 access time met at capture edge
                    check(($time - HALF_PS - t_oe_fall) >= T_AA, "R6 access time",
                          $time - HALF_PS - t_oe_fall, T_AA);
                    check(($time - HALF_PS - t_oe_fall) >= T_OE, "R6 oe access",
                          $time - HALF_PS - t_oe_fall, T_OE);
                end
            end
            if (!req_ready) begin
                busy_cnt++;
            end else if (busy_cnt > 0) begin
                if (busy_q.size() == 0) begin
                    check(1'b0, "R2 unexpected busy", busy_cnt, 0);
                end else begin
                    automatic int eb = busy_q.pop_front();
                    // R2 R7 R9 busy span
                    check(busy_cnt == eb, "R9 busy cycles", busy_cnt, eb);
                end
                busy_cnt = 0;
                // R8 idle leaves select high
                check(sram_ce_n == 1'b1, "R8 idle select", sram_ce_n, 1);
            end
            if (mdl_drive) begin
                // R7 no second driver while memory drives
                if (sram_dq !== mem[sram_addr])
                    check(1'b0, "R7 bus contention", sram_dq, mem[sram_addr]);
            end
        end
    end

    task automatic finish_run;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check(sram_ce_n && sram_oe_n && sram_we_n, "R1 strobes high",
              {sram_ce_n, sram_oe_n, sram_we_n}, 7);
        check(req_ready == 1'b1, "R1 ready", req_ready, 1);
        check(rsp_valid == 1'b0, "R1 no response", rsp_valid, 0);
        rst = 1'b0;

        // R10 range ends
        issue(1'b1, 11'd0, 8'hA5);
        issue(1'b1, 11'd2047, 8'h5A);
        issue(1'b0, 11'd0, 8'h00);
        issue(1'b0, 11'd2047, 8'h00);

        // R3 R6 unwritten location reads reset content
        issue(1'b0, 11'd1000, 8'h00);

        // back-to-back write then read of same address
        for (int i = 0; i < 16; i++) begin
            issue(1'b1, 11'((i * 131 + 7) % 2048), 8'(i * 37 + 1));
            issue(1'b0, 11'((i * 131 + 7) % 2048), 8'h00);
        end

        // burst of writes then burst of reads, overwriting one address
        for (int i = 0; i < 12; i++) issue(1'b1, 11'(i * 170), 8'(8'hF0 ^ i));
        issue(1'b1, 11'd170, 8'h3C);
        for (int i = 0; i < 12; i++) issue(1'b0, 11'(i * 170), 8'h00);

        // read immediately followed by write to same place, then read back
        issue(1'b0, 11'd340, 8'h00);
        issue(1'b1, 11'd340, 8'hC3);
        issue(1'b0, 11'd340, 8'h00);

        while (exp_q.size() != 0 || busy_q.size() != 0) @(negedge clk);
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule